// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This unit carries out single-register memory transfers for a small load/store processor core. Each request brings a decoded operation: load or store, an access size, and a signed flag for loads. It also brings a base value, an offset, an add/subtract control, an indexing choice (pre or post), a writeback request and a condition-pass flag. In the cycle it accepts a request, the unit forms the effective address and drives a synchronous memory port. That port has a read/write strobe, four byte enables and store data copied onto every lane.

One cycle later the unit raises a single-cycle `done` pulse. With it come the aligned and extended load value, an updated base value for the register file, and a misalignment flag when the access was refused. Requests travel on a valid/ready handshake. `req_ready` is low during reset and high from the first clock after it, so the unit accepts one request in every cycle and never applies back-pressure. The result side has no ready input: the consumer must take each `done` pulse in the cycle it appears. The memory must return read data exactly one cycle after a read strobe.

Top module: `lsu_xfer_unit`

## Requirements
- R1: In the accept cycle (`req_valid` and `req_ready` both high), `mem_addr` is the updated base when `req_pre`=1 and the unmodified `req_base` when `req_pre`=0.
- R2: The updated base is `req_base + req_offset` when `req_up`=1 and `req_base - req_offset` when `req_up`=0, both modulo 2^ADDR_W.
- R3: In the cycle after an executed access, `wb_en` is 1 for post-indexed requests, and for pre-indexed requests only when `req_wb`=1. When `wb_en`=1, `wb_data` carries the updated base.
- R4: Size encoding is 00 byte, 01 halfword, 10 word (11 is reserved). Byte enables are: byte gives `1 << mem_addr[1:0]`; halfword gives 0011 when `mem_addr[1]`=0 and 1100 when it is 1; word gives 1111. Bit i enables data bits 8i+7..8i.
- R5: A store sets `mem_we`=1. `mem_wdata` is the low byte copied four times for bytes, the low halfword copied twice for halfwords, and `req_wdata` unchanged for words.
- R6: In the cycle after an executed load, `ld_valid`=1 and `rd_data` holds the addressed lane of `mem_rdata`. The lane is zero-extended when `req_signed`=0 and sign-extended to 32 bits when `req_signed`=1. A word load returns all 32 bits.
- R7: When `req_cond_ok`=0, the accepted request produces no memory strobe, and in the following cycle `wb_en`, `ld_valid` and `misalign` stay 0.
- R8: A halfword with address bit 0 set, or a word with either low address bit set, is misaligned when the condition passes. It raises `misalign` in the next cycle and produces no memory strobe, no writeback and no load result.
- R9: `done` is high for exactly the cycle after each accepted request and low after a cycle with nothing accepted.
- R10: While `rst_n` is low, `req_ready`, `mem_en`, `done`, `wb_en`, `ld_valid` and `misalign` are 0. `req_ready` is 1 from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_is_load | input | 1 | 1 load, 0 store |
| req_size | input | 2 | Access size (00 byte, 01 half, 10 word) |
| req_signed | input | 1 | Sign-extend load result |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | ADDR_W | Offset magnitude |
| req_up | input | 1 | 1 add offset, 0 subtract |
| req_pre | input | 1 | 1 pre-indexed, 0 post-indexed |
| req_wb | input | 1 | Writeback request for pre-indexed mode |
| req_cond_ok | input | 1 | Condition passed |
| req_wdata | input | 32 | Store data (low bits for narrow sizes) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read data, one cycle after a read strobe |
| done | output | 1 | Request finished (one cycle pulse) |
| misalign | output | 1 | Request refused as misaligned |
| ld_valid | output | 1 | `rd_data` holds a load result |
| rd_data | output | 32 | Aligned, extended load value |
| wb_en | output | 1 | Write `wb_data` to the base register |
| wb_data | output | ADDR_W | Updated base value |

## Verification
The properties assume that `req_size` never carries the reserved code 11. They also assume the memory answers a read strobe with data in exactly the next cycle, so a load result can be tied to the strobe one cycle earlier. The bench draws sizes only from the three legal codes. Its memory model is a small word array that responds on every strobe with that fixed latency. Base and offset values are kept small so that every access, including subtract wraps, lands in the modelled array.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int unsigned LSU_DW    = 32;
  localparam int unsigned LSU_LANES = LSU_DW / 8;
  localparam int unsigned LSU_LW    = $clog2(LSU_LANES);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // Misaligned when the access does not fit its natural boundary.
  function automatic logic lsu_misaligned(input logic [1:0] size,
                                          input logic [LSU_LW-1:0] lo);
    case (size)
      SZ_BYTE: lsu_misaligned = 1'b0;
      SZ_HALF: lsu_misaligned = lo[0];
      default: lsu_misaligned = |lo;
    endcase
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          up,
  input  logic          pre,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] upd
);
  assign upd = up ? (base + offset) : (base - offset);
  assign ea  = pre ? upd : base;
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_pkg::*;
(
  input  logic [1:0]           size,
  input  logic [LSU_LW-1:0]    lo,
  input  logic [LSU_DW-1:0]    wdata,
  output logic [LSU_LANES-1:0] be,
  output logic [LSU_DW-1:0]    wrep
);
  for (genvar g = 0; g < LSU_LANES; g++) begin : g_lane
    localparam logic [LSU_LW-1:0] LN = LSU_LW'(g);
    logic       en;
    logic [7:0] dat;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          en  = (lo == LN);
          dat = wdata[7:0];
        end
        SZ_HALF: begin
          en  = (lo[1] == LN[1]);
          dat = wdata[8*(g%2) +: 8];
        end
        default: begin
          en  = 1'b1;
          dat = wdata[8*g +: 8];
        end
      endcase
    end
    assign be[g]          = en;
    assign wrep[8*g +: 8] = dat;
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [LSU_LW-1:0] lo,
  input  logic              sgn,
  input  logic [LSU_DW-1:0] rdata,
  output logic [LSU_DW-1:0] value
);
  logic [LSU_DW-1:0] shifted;

  assign shifted = rdata >> {lo, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: value = {{(LSU_DW-8){sgn & shifted[7]}},   shifted[7:0]};
      SZ_HALF: value = {{(LSU_DW-16){sgn & shifted[15]}}, shifted[15:0]};
      default: value = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_xfer_unit.sv
module lsu_xfer_unit
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_is_load,
  input  logic [1:0]           req_size,
  input  logic                 req_signed,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [ADDR_W-1:0]    req_offset,
  input  logic                 req_up,
  input  logic                 req_pre,
  input  logic                 req_wb,
  input  logic                 req_cond_ok,
  input  logic [LSU_DW-1:0]    req_wdata,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LSU_LANES-1:0] mem_be,
  output logic [LSU_DW-1:0]    mem_wdata,
  input  logic [LSU_DW-1:0]    mem_rdata,
  output logic                 done,
  output logic                 misalign,
  output logic                 ld_valid,
  output logic [LSU_DW-1:0]    rd_data,
  output logic                 wb_en,
  output logic [ADDR_W-1:0]    wb_data
);
  logic                 rdy_q;
  logic                 accept, bad, go;
  logic [ADDR_W-1:0]    ea, upd;
  logic [LSU_LANES-1:0] be_raw;
  logic [LSU_DW-1:0]    wrep;

  logic                 done_q, mis_q, ld_q, wb_q;
  logic [ADDR_W-1:0]    wbd_q;
  logic [1:0]           size_q;
  logic [LSU_LW-1:0]    lo_q;
  logic                 sgn_q;

  lsu_agen #(.AW(ADDR_W)) u_agen (
    .base   (req_base),
    .offset (req_offset),
    .up     (req_up),
    .pre    (req_pre),
    .ea     (ea),
    .upd    (upd)
  );

  lsu_lane_steer u_steer (
    .size  (req_size),
    .lo    (ea[LSU_LW-1:0]),
    .wdata (req_wdata),
    .be    (be_raw),
    .wrep  (wrep)
  );

  assign accept = req_valid & rdy_q;
  assign bad    = accept & req_cond_ok & lsu_misaligned(req_size, ea[LSU_LW-1:0]);
  assign go     = accept & req_cond_ok & ~bad;

  assign req_ready = rdy_q;
  assign mem_en    = go;
  assign mem_we    = go & ~req_is_load;
  assign mem_addr  = ea;
  assign mem_be    = go ? be_raw : '0;
  assign mem_wdata = wrep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
      mis_q  <= 1'b0;
      ld_q   <= 1'b0;
      wb_q   <= 1'b0;
      wbd_q  <= '0;
      size_q <= SZ_WORD;
      lo_q   <= '0;
      sgn_q  <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
      done_q <= accept;
      mis_q  <= bad;
      ld_q   <= go & req_is_load;
      wb_q   <= go & (~req_pre | req_wb);
      if (accept) begin
        wbd_q  <= upd;
        size_q <= req_size;
        lo_q   <= ea[LSU_LW-1:0];
        sgn_q  <= req_signed;
      end
    end
  end

  lsu_load_align u_align (
    .size  (size_q),
    .lo    (lo_q),
    .sgn   (sgn_q),
    .rdata (mem_rdata),
    .value (rd_data)
  );

  assign done     = done_q;
  assign misalign = mis_q;
  assign ld_valid = ld_q;
  assign wb_en    = wb_q;
  assign wb_data  = wbd_q;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_size,
  input logic          req_pre,
  input logic          req_cond_ok,
  input logic [AW-1:0] req_base,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          done,
  input logic          misalign,
  input logic          wb_en,
  input logic          ld_valid
);
  AST_POST_USES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_pre) |-> (mem_addr == req_base)); // R1

  AST_POST_WRITES_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_pre) |=> wb_en); // R3

  AST_BYTE_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && req_size == 2'b00) |-> ($countones(mem_be) == 1)); // R4

  AST_READ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> ld_valid); // R6

  AST_COND_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_cond_ok) |-> !mem_en); // R7

  AST_COND_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_cond_ok) |=> (!wb_en && !ld_valid && !misalign)); // R7

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!wb_en && !ld_valid)); // R8

  AST_WORD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && req_size == 2'b10) |-> (mem_addr[1:0] == 2'b00 && mem_be == 4'hF)); // R8

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> done); // R9

  AST_DONE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready)); // R9

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> !mem_en); // R9
endmodule

bind lsu_xfer_unit lsu_checker #(.AW(ADDR_W)) u_chk (.*);

// File: tb/tb_lsu_xfer_unit.sv
module tb_lsu_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_is_load, req_signed;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_offset, req_wdata;
  logic        req_up, req_pre, req_wb, req_cond_ok;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        done, misalign, ld_valid, wb_en;
  logic [31:0] rd_data, wb_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lsu_xfer_unit dut (.*);

  // memory model: 16 words, one-cycle read latency
  logic [31:0] mem_arr [16];
  logic [31:0] sh [16];

  function automatic logic [31:0] init_word(input int i);
    return 32'h8F7E_F180 ^ (32'(i) * 32'h1357_9BDF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem_arr[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_arr[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem_arr[mem_addr[5:2]];
      end
    end
  end

  // expected-value functions from the requirements
  function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'b00:   return 4'b0001 << lo;
      2'b01:   return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] f_rep(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] f_ld(input logic [1:0] sz, input logic [1:0] lo,
                                       input logic sg, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*lo +: 8];
    h = lo[1] ? w[31:16] : w[15:0];
    case (sz)
      2'b00:   return sg ? {{24{b[7]}}, b} : {24'h0, b};
      2'b01:   return sg ? {{16{h[15]}}, h} : {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pending expectations for the cycle after a request
  bit          p_done, p_mis, p_wb, p_ld;
  logic [31:0] p_wbd, p_ldv;

  task automatic check_prev();
    chk(done == p_done, "R9 done", 32'(done), 32'(p_done));
    chk(misalign == p_mis, "R8 misalign", 32'(misalign), 32'(p_mis));
    chk(wb_en == p_wb, "R3 wb_en", 32'(wb_en), 32'(p_wb));
    if (p_wb) chk(wb_data == p_wbd, "R2 wb_data", wb_data, p_wbd);
    chk(ld_valid == p_ld, "R6 ld_valid", 32'(ld_valid), 32'(p_ld));
    if (p_ld) chk(rd_data == p_ldv, "R6 rd_data", rd_data, p_ldv);
  endtask

  task automatic idle();
    @(negedge clk);
    check_prev();
    req_valid = 1'b0;
    #1;
    chk(mem_en == 1'b0, "R9 idle strobe", 32'(mem_en), 32'h0);
    p_done = 0; p_mis = 0; p_wb = 0; p_ld = 0;
  endtask

  task automatic xfer(input bit ld, input logic [1:0] sz, input bit sg,
                      input logic [31:0] base, input logic [31:0] off,
                      input bit up, input bit pre, input bit wb, input bit cnd,
                      input logic [31:0] wd);
    logic [31:0] upd, ea;
    bit mis, go;
    @(negedge clk);
    check_prev();
    req_valid = 1'b1; req_is_load = ld; req_size = sz; req_signed = sg;
    req_base = base; req_offset = off; req_up = up; req_pre = pre;
    req_wb = wb; req_cond_ok = cnd; req_wdata = wd;
    upd = up ? base + off : base - off;
    ea  = pre ? upd : base;
    mis = cnd && ((sz == 2'b01 && ea[0]) || (sz == 2'b10 && ea[1:0] != 2'b00));
    go  = cnd && !mis;
    #1;
    if (!cnd) chk(mem_en == 1'b0, "R7 no strobe", 32'(mem_en), 32'h0);
    else if (mis) chk(mem_en == 1'b0, "R8 no strobe", 32'(mem_en), 32'h0);
    else begin
      chk(mem_en == 1'b1, "R1 strobe", 32'(mem_en), 32'h1);
      chk(mem_addr == ea, "R1 address", mem_addr, ea);
      chk(mem_be == f_be(sz, ea[1:0]), "R4 byte enables", 32'(mem_be), 32'(f_be(sz, ea[1:0])));
      chk(mem_we == !ld, "R5 write", 32'(mem_we), 32'(!ld));
      if (!ld) chk(mem_wdata == f_rep(sz, wd), "R5 store data", mem_wdata, f_rep(sz, wd));
    end
    p_done = 1;
    p_mis  = mis;
    p_wb   = go && (!pre || wb);
    p_wbd  = upd;
    p_ld   = go && ld;
    p_ldv  = f_ld(sz, ea[1:0], sg, sh[ea[5:2]]);
    if (go && !ld)
      for (int b = 0; b < 4; b++)
        if (f_be(sz, ea[1:0])[b]) sh[ea[5:2]][8*b +: 8] = f_rep(sz, wd)[8*b +: 8];
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 16; i++) sh[i] = init_word(i);
    rst_n = 1'b0;
    req_valid = 0; req_is_load = 0; req_size = 2'b10; req_signed = 0;
    req_base = 0; req_offset = 0; req_up = 0; req_pre = 0; req_wb = 0;
    req_cond_ok = 0; req_wdata = 0;
    p_done = 0; p_mis = 0; p_wb = 0; p_ld = 0; p_wbd = 0; p_ldv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_cond_ok = 1'b1;
    #1;
    // R10 reset state
    chk(req_ready == 1'b0, "R10 ready in reset", 32'(req_ready), 32'h0);
    chk(mem_en == 1'b0, "R10 strobe in reset", 32'(mem_en), 32'h0);
    chk({done, wb_en, ld_valid, misalign} == 4'b0, "R10 outputs in reset",
        32'({done, wb_en, ld_valid, misalign}), 32'h0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);

    // directed: pre-indexed word store, no writeback request (R1 R3 R5)
    xfer(0, 2'b10, 0, 32'd4, 32'd4, 1, 1, 0, 1, 32'h8001_F27F);
    // loads from word 8: lanes with signed/unsigned extension (R6)
    xfer(1, 2'b00, 1, 32'd8, 32'd0, 1, 1, 0, 1, 0);   // 7F
    xfer(1, 2'b00, 1, 32'd9, 32'd0, 1, 1, 0, 1, 0);   // F2 signed
    xfer(1, 2'b00, 0, 32'd9, 32'd0, 1, 1, 0, 1, 0);   // F2 unsigned
    xfer(1, 2'b01, 1, 32'd10, 32'd0, 1, 1, 0, 1, 0);  // 8001 signed
    xfer(1, 2'b01, 0, 32'd10, 32'd0, 1, 1, 0, 1, 0);  // 8001 unsigned
    // post-indexed word load, subtract: address = base, wb = base-4 (R1 R2 R3)
    xfer(1, 2'b10, 0, 32'd8, 32'd4, 0, 0, 0, 1, 0);
    // condition false store, then reread (R7)
    xfer(0, 2'b10, 0, 32'd8, 32'd0, 1, 1, 1, 0, 32'h0);
    xfer(1, 2'b10, 0, 32'd8, 32'd0, 1, 1, 0, 1, 0);
    // misaligned word and halfword (R8)
    xfer(0, 2'b10, 0, 32'd9, 32'd0, 1, 1, 1, 1, 32'h1234_5678);
    xfer(1, 2'b01, 1, 32'd8, 32'd3, 1, 1, 1, 1, 0);
    // byte store on lane 1 of word 12, halfword store upper half (R4 R5)
    xfer(0, 2'b00, 0, 32'd12, 32'd1, 1, 1, 1, 1, 32'h0000_00AB);
    xfer(0, 2'b01, 0, 32'd14, 32'd0, 1, 0, 0, 1, 32'h0000_C3D4);
    xfer(1, 2'b10, 0, 32'd12, 32'd0, 1, 1, 0, 1, 0);
    idle();
    // pre-indexed with writeback request (R3)
    xfer(1, 2'b10, 0, 32'd20, 32'd4, 1, 1, 1, 1, 0);
    idle();

    // constrained random
    for (int t = 0; t < 600; t++) begin
      if ($urandom_range(0, 9) == 0) idle();
      else
        xfer($urandom_range(0, 1), 2'($urandom_range(0, 2)), $urandom_range(0, 1),
             32'($urandom_range(0, 63)), 32'($urandom_range(0, 15)),
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 9) != 0, $urandom());
    end
    idle();
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule